// File: doc/BRIEF.md
# Event and Cycle Performance Counter Unit

This block counts hardware events and clock cycles for software profiling. Each of its configurable 32-bit event counters is tied to one event number. The event number indexes a vector of single-cycle pulses that the rest of the chip drives. A separate 32-bit cycle counter counts clock cycles. It can count every cycle, or once per 64 cycles when the prescaler is on. Software reaches the event counters indirectly: it writes a counter index to a select register, then accesses the type and count windows.

Enables, overflow flags and interrupt enables all use one bit layout: bit 31 is the cycle counter and bits 0 to 5 are the event counters. Enables and interrupt enables each have a set address and a clear address that take a write of ones. Overflow flags are cleared by writing ones. The interrupt output is high while any overflow flag that has its interrupt enabled is set. A bus access is one cycle wide, given by `req_valid_i` and `req_write_i`. Read data appears on `rdata_o` after the next clock edge.

Top module: `perf_counter_unit`

## Requirements
- R1: After reset, every register reads zero, `irq_o` is 0 and `export_o` is 0.
- R2: Control register (offset 0x00) bit 0 is the global run enable. While it is 0, no counter changes except through a bus write.
- R3: Writing 1 to control bit 1 clears every event counter, and writing 1 to control bit 2 clears the cycle counter and its prescaler. Neither bit is stored: both read back 0. Clearing the event counters leaves the cycle counter unchanged.
- R4: With control bit 3 set, the cycle counter (offset 0x14, writable) advances once per 64 running cycles, on the 64th. With bit 3 clear, it advances on every running cycle.
- R5: Control bit 4 is stored and drives `export_o`, and has no other effect.
- R6: The select register (offset 0x10) keeps the low 5 bits of the written value. The type window (0x18) and count window (0x1C) act on the event counter with that index. For an index of 6 or above, both windows read 0 and ignore writes.
- R7: The enable set (0x04) and enable clear (0x08) addresses use bit 31 for the cycle counter and bits 0 to 5 for the event counters. Writing a 1 sets or clears that enable, and writing a 0 leaves it unchanged. A read of either address returns the enable mask.
- R8: An event counter advances by one on each cycle in which the unit is running, its enable is set, and `event_i[type]` is 1. Only event numbers 0x03 and 0x04 are implemented. A counter whose type is any other number never advances and its count window reads 0. The type itself reads back as written.
- R9: A counter that advances from 0xFFFFFFFF wraps to 0 and sets its flag in the overflow register (0x0C). Writing 1 to a flag clears it, and writing 0 has no effect. A wrap in the same cycle as a clear of that flag leaves the flag set.
- R10: The interrupt enable set (0x20) and clear (0x24) addresses follow the R7 layout and rules. `irq_o` is 1 exactly when some overflow flag and its interrupt enable are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Bus access this cycle |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 6 | Byte offset of the register |
| req_wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid the cycle after a read |
| event_i | input | 64 | Event pulses, indexed by event number |
| irq_o | output | 1 | Overflow interrupt |
| export_o | output | 1 | Stored event export enable |

## Verification
Two things can land on the same clock edge: a counter wrapping, which sets an overflow flag, and a software write that clears that flag. The bench creates this case by preloading event counter 0 with 0xFFFFFFFF. It then drives the implemented event pulse in the same cycle as a write of 1 to the overflow register. Reading the overflow register afterwards must show the flag still set, and the count must be zero. A second check runs the global enable against the counter clear: control writes that start and stop counting are placed on exact edges, and the cycle count is predicted from the number of edges.

// File: rtl/perf_counter_pkg.sv
package perf_counter_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 6;
  localparam int SEL_W  = 5;

  localparam logic [ADDR_W-1:0] ADR_CTRL  = 6'h00;
  localparam logic [ADDR_W-1:0] ADR_ENSET = 6'h04;
  localparam logic [ADDR_W-1:0] ADR_ENCLR = 6'h08;
  localparam logic [ADDR_W-1:0] ADR_OVF   = 6'h0C;
  localparam logic [ADDR_W-1:0] ADR_SEL   = 6'h10;
  localparam logic [ADDR_W-1:0] ADR_CYC   = 6'h14;
  localparam logic [ADDR_W-1:0] ADR_TYPE  = 6'h18;
  localparam logic [ADDR_W-1:0] ADR_CNT   = 6'h1C;
  localparam logic [ADDR_W-1:0] ADR_IESET = 6'h20;
  localparam logic [ADDR_W-1:0] ADR_IECLR = 6'h24;

  // control register bit positions
  localparam int CB_EN     = 0;
  localparam int CB_EVCLR  = 1;
  localparam int CB_CYCCLR = 2;
  localparam int CB_DIV    = 3;
  localparam int CB_EXP    = 4;

  localparam int MASK_CYC_BIT = 31;
endpackage

// File: rtl/perf_evt_ctr.sv
module perf_evt_ctr #(
  parameter int          CTR_W     = 32,
  parameter int          EVT_W     = 64,
  parameter int          TYPE_W    = 8,
  parameter logic [63:0] IMPL_MASK = 64'h18
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              clr_i,
  input  logic              type_we_i,
  input  logic              cnt_we_i,
  input  logic [CTR_W-1:0]  wdata_i,
  input  logic [EVT_W-1:0]  event_i,
  output logic [TYPE_W-1:0] type_o,
  output logic [CTR_W-1:0]  cnt_o,
  output logic              wrap_o
);
  localparam int IDX_W = $clog2(EVT_W);

  logic [TYPE_W-1:0] type_q;
  logic [CTR_W-1:0]  cnt_q;
  logic [IDX_W-1:0]  idx;
  logic              supported, inc;

  assign idx       = type_q[IDX_W-1:0];
  assign supported = (type_q[TYPE_W-1:IDX_W] == '0) && IMPL_MASK[idx];
  assign inc       = run_i && supported && event_i[idx];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        type_q <= '0;
    else if (type_we_i) type_q <= wdata_i[TYPE_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (clr_i)    cnt_q <= '0;
    else if (cnt_we_i) cnt_q <= wdata_i;
    else if (inc)      cnt_q <= cnt_q + 1'b1;
  end

  assign wrap_o = inc && !clr_i && !cnt_we_i && (&cnt_q);
  assign type_o = type_q;
  assign cnt_o  = supported ? cnt_q : '0;
endmodule

// File: rtl/perf_cyc_ctr.sv
module perf_cyc_ctr #(
  parameter int CTR_W      = 32,
  parameter int PRESC_LOG2 = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             div_i,
  input  logic             clr_i,
  input  logic             we_i,
  input  logic [CTR_W-1:0] wdata_i,
  output logic [CTR_W-1:0] cnt_o,
  output logic             inc_o,
  output logic             wrap_o
);
  logic [PRESC_LOG2-1:0] presc_q;
  logic [CTR_W-1:0]      cnt_q;
  logic                  tick;

  assign tick  = div_i ? (&presc_q) : 1'b1;
  assign inc_o = run_i && tick;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              presc_q <= '0;
    else if (clr_i)           presc_q <= '0;
    else if (run_i && div_i)  presc_q <= presc_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (we_i)   cnt_q <= wdata_i;
    else if (inc_o)  cnt_q <= cnt_q + 1'b1;
  end

  assign wrap_o = inc_o && !clr_i && !we_i && (&cnt_q);
  assign cnt_o  = cnt_q;
endmodule

// File: rtl/perf_counter_unit.sv
module perf_counter_unit
  import perf_counter_pkg::*;
#(
  parameter int          NUM_CTR    = 6,
  parameter int          EVT_W      = 64,
  parameter int          TYPE_W     = 8,
  parameter int          PRESC_LOG2 = 6,
  parameter logic [63:0] IMPL_MASK  = 64'h18
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [EVT_W-1:0]  event_i,
  output logic              irq_o,
  output logic              export_o
);
  localparam int NV  = NUM_CTR + 1;  // internal vector: event counters then cycle
  localparam int CYC = NUM_CTR;

  function automatic logic [NV-1:0] to_vec(input logic [DATA_W-1:0] d);
    to_vec = {d[MASK_CYC_BIT], d[NUM_CTR-1:0]};
  endfunction

  function automatic logic [DATA_W-1:0] to_reg(input logic [NV-1:0] v);
    to_reg = '0;
    to_reg[NUM_CTR-1:0] = v[NUM_CTR-1:0];
    to_reg[MASK_CYC_BIT] = v[CYC];
  endfunction

  logic              wr, rd;
  logic              gl_en_q, div_q, exp_q;
  logic [SEL_W-1:0]  sel_q;
  logic [NV-1:0]     en_q, ovf_q, inten_q, wrap_vec;
  logic [DATA_W-1:0] cyc_cnt, rdata_q, rd_mux;
  logic              cyc_inc, evt_clr, cyc_clr;
  logic [NUM_CTR-1:0][TYPE_W-1:0] type_arr;
  logic [NUM_CTR-1:0][DATA_W-1:0] cnt_arr;
  logic [TYPE_W-1:0] sel_type;
  logic [DATA_W-1:0] sel_cnt;

  assign wr      = req_valid_i && req_write_i;
  assign rd      = req_valid_i && !req_write_i;
  assign evt_clr = wr && (req_addr_i == ADR_CTRL) && req_wdata_i[CB_EVCLR];
  assign cyc_clr = wr && (req_addr_i == ADR_CTRL) && req_wdata_i[CB_CYCCLR];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gl_en_q <= 1'b0;
      div_q   <= 1'b0;
      exp_q   <= 1'b0;
    end else if (wr && req_addr_i == ADR_CTRL) begin
      gl_en_q <= req_wdata_i[CB_EN];
      div_q   <= req_wdata_i[CB_DIV];
      exp_q   <= req_wdata_i[CB_EXP];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          sel_q <= '0;
    else if (wr && req_addr_i == ADR_SEL) sel_q <= req_wdata_i[SEL_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= '0;
      inten_q <= '0;
    end else if (wr) begin
      if (req_addr_i == ADR_ENSET) en_q    <= en_q | to_vec(req_wdata_i);
      if (req_addr_i == ADR_ENCLR) en_q    <= en_q & ~to_vec(req_wdata_i);
      if (req_addr_i == ADR_IESET) inten_q <= inten_q | to_vec(req_wdata_i);
      if (req_addr_i == ADR_IECLR) inten_q <= inten_q & ~to_vec(req_wdata_i);
    end
  end

  // a wrap in the same cycle as a clear keeps the flag
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ovf_q <= '0;
    else if (wr && req_addr_i == ADR_OVF)
      ovf_q <= (ovf_q & ~to_vec(req_wdata_i)) | wrap_vec;
    else
      ovf_q <= ovf_q | wrap_vec;
  end

  for (genvar i = 0; i < NUM_CTR; i++) begin : g_evt
    logic sel_me;
    assign sel_me = (sel_q == SEL_W'(i));
    perf_evt_ctr #(
      .CTR_W(DATA_W), .EVT_W(EVT_W), .TYPE_W(TYPE_W), .IMPL_MASK(IMPL_MASK)
    ) u_ctr (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .run_i    (gl_en_q && en_q[i]),
      .clr_i    (evt_clr),
      .type_we_i(wr && sel_me && req_addr_i == ADR_TYPE),
      .cnt_we_i (wr && sel_me && req_addr_i == ADR_CNT),
      .wdata_i  (req_wdata_i),
      .event_i  (event_i),
      .type_o   (type_arr[i]),
      .cnt_o    (cnt_arr[i]),
      .wrap_o   (wrap_vec[i])
    );
  end

  perf_cyc_ctr #(.CTR_W(DATA_W), .PRESC_LOG2(PRESC_LOG2)) u_cyc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (gl_en_q && en_q[CYC]),
    .div_i  (div_q),
    .clr_i  (cyc_clr),
    .we_i   (wr && req_addr_i == ADR_CYC),
    .wdata_i(req_wdata_i),
    .cnt_o  (cyc_cnt),
    .inc_o  (cyc_inc),
    .wrap_o (wrap_vec[CYC])
  );

  always_comb begin
    sel_type = '0;
    sel_cnt  = '0;
    for (int i = 0; i < NUM_CTR; i++) begin
      if (sel_q == SEL_W'(i)) begin
        sel_type = type_arr[i];
        sel_cnt  = cnt_arr[i];
      end
    end
  end

  always_comb begin
    rd_mux = '0;
    case (req_addr_i)
      ADR_CTRL:            rd_mux = DATA_W'({exp_q, div_q, 2'b00, gl_en_q});
      ADR_ENSET, ADR_ENCLR: rd_mux = to_reg(en_q);
      ADR_OVF:             rd_mux = to_reg(ovf_q);
      ADR_SEL:             rd_mux = DATA_W'(sel_q);
      ADR_CYC:             rd_mux = cyc_cnt;
      ADR_TYPE:            rd_mux = DATA_W'(sel_type);
      ADR_CNT:             rd_mux = sel_cnt;
      ADR_IESET, ADR_IECLR: rd_mux = to_reg(inten_q);
      default:             rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  rdata_q <= '0;
    else if (rd)  rdata_q <= rd_mux;
  end

  assign rdata_o  = rdata_q;
  assign irq_o    = |(ovf_q & inten_q);
  assign export_o = exp_q;
endmodule

// File: rtl/perf_counter_unit_chk.sv
module perf_counter_unit_chk #(
  parameter int NUM_CTR = 6
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_valid_i,
  input logic             req_write_i,
  input logic [5:0]       req_addr_i,
  input logic [31:0]      req_wdata_i,
  input logic             irq_o,
  input logic             gl_en_q,
  input logic             div_q,
  input logic [31:0]      cyc_cnt,
  input logic             cyc_inc,
  input logic [NUM_CTR:0] en_q,
  input logic [NUM_CTR:0] ovf_q
);
  logic wr;
  assign wr = req_valid_i && req_write_i;

  assert_hold_when_off_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!gl_en_q && !req_valid_i) |=> $stable(cyc_cnt));

  assert_div_spacing_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (div_q && cyc_inc && !req_valid_i) |=> !cyc_inc);

  assert_enable_set_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && req_addr_i == 6'h04 && req_wdata_i[0]) |=> en_q[0]);

  assert_enable_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && req_addr_i == 6'h08 && req_wdata_i[0]) |=> !en_q[0]);

  assert_cycle_wrap_flag_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_inc && (&cyc_cnt) && !req_valid_i) |=> ovf_q[NUM_CTR]);

  assert_irq_needs_flag_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_q == '0) |-> !irq_o);
endmodule

bind perf_counter_unit perf_counter_unit_chk #(.NUM_CTR(NUM_CTR)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_valid_i(req_valid_i),
  .req_write_i(req_write_i),
  .req_addr_i (req_addr_i),
  .req_wdata_i(req_wdata_i),
  .irq_o      (irq_o),
  .gl_en_q    (gl_en_q),
  .div_q      (div_q),
  .cyc_cnt    (cyc_cnt),
  .cyc_inc    (cyc_inc),
  .en_q       (en_q),
  .ovf_q      (ovf_q)
);

// File: tb/perf_counter_unit_test.sv
module perf_counter_unit_test;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        valid = 1'b0, write = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [63:0] ev = '0;
  logic        irq, exp_pin;
  int          n_chk = 0, n_fail = 0;
  logic [31:0] v, v2;
  int          e3, e4;
  bit          done = 1'b0;

  localparam logic [5:0] CTRL = 6'h00, ENSET = 6'h04, ENCLR = 6'h08, OVF = 6'h0C,
                         SEL = 6'h10, CYC = 6'h14, TYP = 6'h18, CNT = 6'h1C,
                         IESET = 6'h20, IECLR = 6'h24;

  always #5 clk = ~clk;

  perf_counter_unit uut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(valid), .req_write_i(write),
    .req_addr_i(addr), .req_wdata_i(wdata), .rdata_o(rdata), .event_i(ev),
    .irq_o(irq), .export_o(exp_pin)
  );

  function automatic int pop2(input logic [63:0] e, input int b);
    return int'(e[b]);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, expv);
    end
  endtask

  // all bus tasks start and end at a falling edge
  task automatic bus(input logic w, input logic [5:0] a, input logic [31:0] d,
                     input logic [63:0] e);
    valid = 1'b1; write = w; addr = a; wdata = d; ev = e;
    @(negedge clk);
    valid = 1'b0; write = 1'b0; ev = '0;
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    bus(1'b1, a, d, '0);
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    bus(1'b0, a, '0, '0);
    d = rdata;
  endtask

  task automatic pulse(input logic [63:0] e);
    ev = e;
    @(negedge clk);
    ev = '0;
  endtask

  task automatic read_ctr(input int i, output logic [31:0] d);
    wr(SEL, 32'(i));
    rd(CNT, d);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(CTRL, v);  check("R1 ctrl", v, 0);
    rd(ENSET, v); check("R1 enable", v, 0);
    rd(OVF, v);   check("R1 overflow", v, 0);
    rd(CYC, v);   check("R1 cycle", v, 0);
    check("R1 irq", 32'(irq), 0);
    check("R1 export", 32'(exp_pin), 0);

    // R7 enable set/clear
    wr(ENSET, 32'h8000_0005);
    rd(ENSET, v); check("R7 set", v, 32'h8000_0005);
    wr(ENCLR, 32'h0000_0004);
    rd(ENCLR, v); check("R7 clear", v, 32'h8000_0001);
    wr(ENSET, 32'h0); wr(ENCLR, 32'h0);
    rd(ENSET, v); check("R7 zero write no effect", v, 32'h8000_0001);

    // R8 configure types
    wr(SEL, 0); wr(TYP, 32'h04);
    wr(SEL, 1); wr(TYP, 32'h03);
    wr(SEL, 2); wr(TYP, 32'h03);
    wr(SEL, 3); wr(TYP, 32'h11);
    rd(TYP, v); check("R8 type readback", v, 32'h11);
    wr(ENSET, 32'h8000_003F);

    // R2 no counting while globally off
    for (int k = 0; k < 10; k++) pulse(64'h0002_0018);
    read_ctr(0, v); check("R2 counter held when off", v, 0);

    // R8 random event streams
    e3 = 0; e4 = 0;
    wr(CTRL, 32'h1);
    for (int k = 0; k < 300; k++) begin
      logic [63:0] r;
      r = {$urandom(), $urandom()};
      e3 += pop2(r, 3); e4 += pop2(r, 4);
      pulse(r);
    end
    wr(CTRL, 32'h0);
    read_ctr(0, v); check("R8 event 4 count", v, 32'(e4));
    read_ctr(1, v); check("R8 event 3 count", v, 32'(e3));
    read_ctr(2, v); check("R8 event 3 second counter", v, 32'(e3));
    read_ctr(3, v); check("R8 unsupported reads zero", v, 0);

    // R6 selection out of range
    wr(SEL, 32'h25);
    rd(SEL, v); check("R6 select low bits", v, 32'h05);
    wr(SEL, 6); wr(CNT, 32'h55); rd(CNT, v); check("R6 out of range count", v, 0);
    rd(TYP, v); check("R6 out of range type", v, 0);
    read_ctr(0, v); check("R6 counter untouched", v, 32'(e4));

    // R3 clears
    rd(CYC, v2);
    wr(CTRL, 32'h2);
    rd(CTRL, v); check("R3 action bits not stored", v, 0);
    read_ctr(0, v); check("R3 event counter cleared", v, 0);
    rd(CYC, v); check("R3 cycle counter kept", v, v2);
    wr(CTRL, 32'h4);
    rd(CYC, v); check("R3 cycle counter cleared", v, 0);

    // R4 exact cycle count, undivided: 50 running edges
    wr(CTRL, 32'h1);
    repeat (49) @(negedge clk);
    wr(CTRL, 32'h0);
    rd(CYC, v); check("R4 undivided count", v, 50);

    // R4 divided: 200 running edges -> 3
    wr(CTRL, 32'h4);
    wr(CTRL, 32'h9);
    repeat (199) @(negedge clk);
    wr(CTRL, 32'h8);
    rd(CYC, v); check("R4 divided count", v, 3);
    wr(CTRL, 32'h4);

    // R5 export bit
    wr(CTRL, 32'h10);
    check("R5 export pin", 32'(exp_pin), 1);
    rd(CTRL, v); check("R5 export readback", v, 32'h10);
    wr(CTRL, 32'h0);
    check("R5 export off", 32'(exp_pin), 0);

    // R9 wrap and overflow flag
    wr(SEL, 0); wr(CNT, 32'hFFFF_FFFE);
    wr(CTRL, 32'h1);
    pulse(64'h10); pulse(64'h10);
    wr(CTRL, 32'h0);
    read_ctr(0, v); check("R9 wrap to zero", v, 0);
    rd(OVF, v); check("R9 flag set", v, 32'h1);
    check("R10 irq masked", 32'(irq), 0);
    wr(IESET, 32'h1);
    rd(IESET, v); check("R10 inten set", v, 32'h1);
    check("R10 irq raised", 32'(irq), 1);
    wr(OVF, 32'h0);
    check("R9 zero write keeps flag", 32'(irq), 1);
    wr(OVF, 32'h1);
    rd(OVF, v); check("R9 flag cleared", v, 0);
    check("R10 irq dropped", 32'(irq), 0);

    // R9 wrap in the same cycle as clear: flag stays
    wr(SEL, 0); wr(CNT, 32'hFFFF_FFFF);
    wr(CTRL, 32'h1);
    bus(1'b1, OVF, 32'h1, 64'h10);
    wr(CTRL, 32'h0);
    rd(OVF, v); check("R9 set wins over clear", v, 32'h1);
    read_ctr(0, v); check("R9 same-cycle wrap value", v, 0);
    wr(OVF, 32'hFFFF_FFFF);

    // R9/R10 cycle counter wrap and interrupt clear
    wr(IESET, 32'h8000_0000);
    wr(CYC, 32'hFFFF_FFFF);
    wr(CTRL, 32'h1);
    wr(CTRL, 32'h0);
    rd(CYC, v); check("R9 cycle wrap", v, 0);
    rd(OVF, v); check("R9 cycle flag", v, 32'h8000_0000);
    check("R10 irq from cycle", 32'(irq), 1);
    wr(IECLR, 32'h8000_0000);
    check("R10 inten clear", 32'(irq), 0);
    rd(IECLR, v); check("R10 inten readback", v, 32'h1);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule